// File: doc/BRIEF.md
# Token-Ring Readout Controller with Byte Framing

This controller collects time-digitizer data from a small chain of sources that share one 32-bit readout bus by passing a token. Source 0 is the ring master. When an event start arrives, the controller emits an event header word. It then hands the token to each source in turn, starting at source 0. For every word it accepts, it raises that source's get signal. After all sources have been served, it closes the event with a trailer word. The sources put the source index, the channel index and the time value into the data word. The controller forwards that word unchanged.

All handshake decisions are taken on a half-rate tick, so a source sees the handshake paced at half the system clock. The controller splits every word into four 11-bit frames for a serial link, most significant byte first. Each frame carries a byte-position tag and an odd-parity bit. Two kinds of source are bypassed so that readout of the rest of the ring continues: a source that flags an error while it holds the token, and a source that does not answer within a time limit. When any source was bypassed, an error word that carries the bypass mask is placed just before the trailer.

Top module: `rdo_ring_readout`

## Requirements
- R1: After reset, `get_data_o`, `token_o` and `frame_stb_o` are all zero.
- R2: Each `get_data_o` pulse lasts exactly two clock cycles. `frame_stb_o` is never high in two consecutive cycles.
- R3: The first word of each event is the header {4'hA, 12'h000, event number[15:0]}. The event number is 0 for the first event after reset and increases by one per event. The last word is the trailer {4'hC, 12'h000, count[15:0]}, where count is the number of source data words in the event.
- R4: Sources are served in index order 0 to N_SRC-1. Their words appear in the order they were offered. A source keeps the token until a word offered with its `src_last_i` bit high is accepted.
- R5: Each word is sent as four frames {id[1:0], parity, data[7:0]}. The id runs 0, 1, 2, 3, and id 0 carries bits 31:24.
- R6: Every frame has odd parity over its 8 data bits plus the parity bit.
- R7: A source whose `src_err_i` bit is high while it holds the token is bypassed. It never receives `get_data_o`, and the token moves on.
- R8: A token holder that keeps `src_rdy_i` low for TMO_CYC (default 64) clock cycles is bypassed. It never receives `get_data_o`.
- R9: If any source was bypassed, the word {4'hE, 24'h0, bypass mask[3:0]} (bit i = source i) comes just before the trailer. Otherwise no such word is emitted.
- R10: `evt_start_i` is ignored while an event is in progress. It adds no bytes, and the event number advances by only one.
- R11: `get_data_o` is one-hot or zero. It rises only for a source whose `src_rdy_i` bit was high and whose `src_err_i` bit was low on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_start_i | input | 1 | Pulse that starts readout of one event |
| src_rdy_i | input | N_SRC | Per-source data-ready |
| src_err_i | input | N_SRC | Per-source error flag |
| src_last_i | input | N_SRC | Offered word is the source's last |
| src_data_i | input | 32 | Shared readout bus, driven by the token holder |
| get_data_o | output | N_SRC | Per-source word acknowledge, two cycles wide |
| token_o | output | N_SRC | One-hot token holder during the ring pass |
| frame_o | output | 11 | {byte id, parity, data byte} |
| frame_stb_o | output | 1 | One-cycle strobe for a valid `frame_o` |

## Verification
The properties assume a well-behaved ring. Only the token holder drives the bus and raises ready, error or last. A source holds its word steady until it sees its get pulse, and then presents its next word or releases the token. The bench source models build their ready and error signals from `token_o`, gated by each source's configured behaviour (normal, erroring or silent). They update on the falling edge after a get pulse is seen, so every value the controller samples comes from a single token holder.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WAIT,
    ST_ERRW,
    ST_TRL
  } rdo_state_e;

  localparam logic [3:0] TAG_HDR = 4'hA;
  localparam logic [3:0] TAG_ERR = 4'hE;
  localparam logic [3:0] TAG_TRL = 4'hC;

  // odd parity bit: total ones over data plus this bit is odd
  function automatic logic odd_par(input logic [7:0] b);
    return ~(^b);
  endfunction

endpackage

// File: rtl/rdo_pacer.sv
module rdo_pacer (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  logic ph_q;
  logic ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign tick_o = ph_q;

endmodule

// File: rtl/rdo_byte_framer.sv
module rdo_byte_framer #(
  parameter int W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick_i,
  input  logic                          load_i,
  input  logic [W-1:0]                  word_i,
  output logic                          rdy_o,
  output logic [$clog2(W/8)+8:0]        frame_o,
  output logic                          stb_o
);
  import rdo_pkg::*;

  localparam int BYTES = W / 8;
  localparam int CW    = $clog2(BYTES + 1);
  localparam int IDW   = $clog2(BYTES);
  localparam int FW    = IDW + 9;

  logic [W-1:0]  sh_q,  sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [FW-1:0] fr_q,  fr_d;
  logic          stb_q, stb_d;
  logic [7:0]    top_byte;

  assign top_byte = sh_q[W-1 -: 8];

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    fr_d  = fr_q;
    stb_d = 1'b0;
    if (tick_i && cnt_q != '0) begin
      fr_d  = {IDW'(BYTES - int'(cnt_q)), odd_par(top_byte), top_byte};
      sh_d  = sh_q << 8;
      cnt_d = cnt_q - 1'b1;
      stb_d = 1'b1;
    end
    if (tick_i && load_i) begin
      sh_d  = word_i;
      cnt_d = CW'(BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      fr_q  <= '0;
      stb_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      fr_q  <= fr_d;
      stb_q <= stb_d;
    end
  end

  // ready for a new word while idle or while the last byte goes out
  assign rdy_o   = (cnt_q <= CW'(1));
  assign frame_o = fr_q;
  assign stb_o   = stb_q;

endmodule

// File: rtl/rdo_ring_seq.sv
module rdo_ring_seq #(
  parameter int N_SRC   = 4,
  parameter int TMO_CYC = 64,
  parameter int W       = 32,
  parameter int EVW     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [N_SRC-1:0] src_rdy_i,
  input  logic [N_SRC-1:0] src_err_i,
  input  logic [N_SRC-1:0] src_last_i,
  input  logic [W-1:0]     data_i,
  input  logic             fr_rdy_i,
  output logic             load_o,
  output logic [W-1:0]     word_o,
  output logic [N_SRC-1:0] gd_o,
  output logic [N_SRC-1:0] token_o
);
  import rdo_pkg::*;

  localparam int TOKW    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int TMO_TCK = TMO_CYC / 2;
  localparam int TW      = $clog2(TMO_TCK + 1);

  rdo_state_e       st_q,   st_d;
  logic             pend_q, pend_d;
  logic [TOKW-1:0]  tok_q,  tok_d;
  logic [TW-1:0]    tmr_q,  tmr_d;
  logic [N_SRC-1:0] mask_q, mask_d;
  logic [EVW-1:0]   evn_q,  evn_d;
  logic [EVW-1:0]   wcnt_q, wcnt_d;
  logic [N_SRC-1:0] gd_q,   gd_d;
  logic             adv;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    tok_d  = tok_q;
    tmr_d  = tmr_q;
    mask_d = mask_q;
    evn_d  = evn_q;
    wcnt_d = wcnt_q;
    gd_d   = gd_q;
    load_o = 1'b0;
    word_o = data_i;
    adv    = 1'b0;

    if (st_q == ST_IDLE) pend_d = pend_q | start_i;

    if (tick_i) begin
      gd_d = '0;
      unique case (st_q)
        ST_IDLE: begin
          if (pend_q || start_i) begin
            st_d   = ST_HDR;
            pend_d = 1'b0;
          end
        end
        ST_HDR: begin
          if (fr_rdy_i) begin
            load_o = 1'b1;
            word_o = {TAG_HDR, {(W-4-EVW){1'b0}}, evn_q};
            evn_d  = evn_q + 1'b1;
            tok_d  = '0;
            tmr_d  = '0;
            mask_d = '0;
            wcnt_d = '0;
            st_d   = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (src_err_i[tok_q] ||
              (!src_rdy_i[tok_q] && tmr_q == TW'(TMO_TCK - 1))) begin
            mask_d[tok_q] = 1'b1;
            adv           = 1'b1;
          end else if (src_rdy_i[tok_q]) begin
            if (fr_rdy_i) begin
              load_o      = 1'b1;
              gd_d[tok_q] = 1'b1;
              wcnt_d      = wcnt_q + 1'b1;
              tmr_d       = '0;
              adv         = src_last_i[tok_q];
            end
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
          if (adv) begin
            tmr_d = '0;
            if (tok_q == TOKW'(N_SRC - 1))
              st_d = (mask_d != '0) ? ST_ERRW : ST_TRL;
            else
              tok_d = tok_q + 1'b1;
          end
        end
        ST_ERRW: begin
          if (fr_rdy_i) begin
            load_o = 1'b1;
            word_o = {TAG_ERR, {(W-4-N_SRC){1'b0}}, mask_q};
            st_d   = ST_TRL;
          end
        end
        ST_TRL: begin
          if (fr_rdy_i) begin
            load_o = 1'b1;
            word_o = {TAG_TRL, {(W-4-EVW){1'b0}}, wcnt_q};
            st_d   = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      tok_q  <= '0;
      tmr_q  <= '0;
      mask_q <= '0;
      evn_q  <= '0;
      wcnt_q <= '0;
      gd_q   <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      tok_q  <= tok_d;
      tmr_q  <= tmr_d;
      mask_q <= mask_d;
      evn_q  <= evn_d;
      wcnt_q <= wcnt_d;
      gd_q   <= gd_d;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_tok
    assign token_o[g] = (st_q == ST_WAIT) && (tok_q == TOKW'(g));
  end

  assign gd_o = gd_q;

endmodule

// File: rtl/rdo_ring_readout.sv
module rdo_ring_readout #(
  parameter int N_SRC   = 4,
  parameter int TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_start_i,
  input  logic [N_SRC-1:0] src_rdy_i,
  input  logic [N_SRC-1:0] src_err_i,
  input  logic [N_SRC-1:0] src_last_i,
  input  logic [31:0]      src_data_i,
  output logic [N_SRC-1:0] get_data_o,
  output logic [N_SRC-1:0] token_o,
  output logic [10:0]      frame_o,
  output logic             frame_stb_o
);

  localparam int W = 32;

  logic         tick;
  logic         fr_rdy;
  logic         load;
  logic [W-1:0] word;

  rdo_pacer pacer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  rdo_ring_seq #(
    .N_SRC   (N_SRC),
    .TMO_CYC (TMO_CYC),
    .W       (W),
    .EVW     (16)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .start_i    (evt_start_i),
    .src_rdy_i  (src_rdy_i),
    .src_err_i  (src_err_i),
    .src_last_i (src_last_i),
    .data_i     (src_data_i),
    .fr_rdy_i   (fr_rdy),
    .load_o     (load),
    .word_o     (word),
    .gd_o       (get_data_o),
    .token_o    (token_o)
  );

  rdo_byte_framer #(
    .W (W)
  ) framer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .load_i  (load),
    .word_i  (word),
    .rdy_o   (fr_rdy),
    .frame_o (frame_o),
    .stb_o   (frame_stb_o)
  );

endmodule

// File: rtl/rdo_ring_readout_chk.sv
module rdo_ring_readout_chk #(
  parameter int N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_rdy_i,
  input logic [N_SRC-1:0] src_err_i,
  input logic [N_SRC-1:0] get_data_o,
  input logic [N_SRC-1:0] token_o,
  input logic [10:0]      frame_o,
  input logic             frame_stb_o
);

  assert_gd_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(get_data_o));

  assert_gd_from_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|get_data_o) |-> ((get_data_o & $past(src_rdy_i)) != '0));

  assert_gd_not_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|get_data_o) |-> ((get_data_o & $past(src_err_i)) == '0));

  assert_gd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|get_data_o) |=> (|get_data_o));

  assert_gd_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|get_data_o) && $past(|get_data_o)) |=> !(|get_data_o));

  assert_stb_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o |=> !frame_stb_o);

  assert_frame_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb_o |-> (^frame_o[8:0]));

  assert_token_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(token_o));

endmodule

bind rdo_ring_readout rdo_ring_readout_chk #(.N_SRC(N_SRC)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_rdy_i   (src_rdy_i),
  .src_err_i   (src_err_i),
  .get_data_o  (get_data_o),
  .token_o     (token_o),
  .frame_o     (frame_o),
  .frame_stb_o (frame_stb_o)
);

// File: tb/rdo_ring_readout_tb_top.sv
module rdo_ring_readout_tb_top;

  localparam int NS = 4;

  logic          clk;
  logic          rst_n;
  logic          evt_start;
  logic [NS-1:0] rdy, err, last, gd, tok;
  logic [31:0]   data;
  logic [10:0]   frame;
  logic          stb;

  int total = 0;
  int bad   = 0;

  int nw [NS];
  int md [NS];   // 0 normal, 1 error, 2 silent
  int idx[NS];

  logic [10:0] bq[0:255];
  int          bn = 0;
  int          evexp = 0;

  int gd_run  [NS];
  int bad_w   = 0;
  int bad_g   = 0;
  int bad_s   = 0;
  logic [NS-1:0] gd_prev = '0;
  logic          stb_prev = 1'b0;

  rdo_ring_readout #(.N_SRC(NS), .TMO_CYC(64)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_start_i (evt_start),
    .src_rdy_i   (rdy),
    .src_err_i   (err),
    .src_last_i  (last),
    .src_data_i  (data),
    .get_data_o  (gd),
    .token_o     (tok),
    .frame_o     (frame),
    .frame_stb_o (stb)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] dw(input int i, input int k);
    return {4'h3, 2'(i), 2'b00, 8'(k), 16'hB0C0 ^ 16'(i * 37 + k)};
  endfunction

  // source models and monitors, evaluated away from the active edge
  always @(negedge clk) begin
    for (int i = 0; i < NS; i++) begin
      if (gd[i] && !gd_prev[i]) begin
        if (md[i] != 0) bad_g++;
        idx[i]++;
        gd_run[i] = 1;
      end else if (gd[i]) begin
        gd_run[i]++;
      end else if (gd_prev[i] && gd_run[i] != 2) begin
        bad_w++;
      end
    end
    gd_prev <= gd;
    if (stb && stb_prev) bad_s++;
    stb_prev <= stb;
    if (stb && bn < 256) begin
      bq[bn] = frame;
      bn++;
    end
    data <= '0;
    for (int i = 0; i < NS; i++) begin
      rdy[i]  <= tok[i] && md[i] == 0 && idx[i] < nw[i];
      err[i]  <= tok[i] && md[i] == 1;
      last[i] <= (idx[i] == nw[i] - 1);
      if (tok[i]) data <= dw(i, idx[i]);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_event(input bit poke);
    logic [31:0] ew[0:63];
    int en = 0;
    int cnt = 0;
    logic [3:0] mask = '0;
    bit par_ok = 1, id_ok = 1;
    int waited = 0;
    ew[en++] = {4'hA, 12'h000, 16'(evexp)};
    for (int i = 0; i < NS; i++) begin
      if (md[i] == 0) begin
        for (int k = 0; k < nw[i]; k++) begin
          ew[en++] = dw(i, k);
          cnt++;
        end
      end else begin
        mask[i] = 1'b1;
      end
    end
    if (mask != 0) ew[en++] = {4'hE, 24'h0, mask};
    ew[en++] = {4'hC, 12'h000, 16'(cnt)};
    for (int i = 0; i < NS; i++) idx[i] = 0;
    bn = 0;
    @(negedge clk); evt_start = 1'b1;
    @(negedge clk); evt_start = 1'b0;
    if (poke) begin
      repeat (30) @(negedge clk);
      evt_start = 1'b1;
      @(negedge clk); evt_start = 1'b0;
    end
    while (bn < 4 * en && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    repeat (60) @(negedge clk);
    chk(bn == 4 * en, poke ? "R10" : "R3", "frame count", 32'(bn), 32'(4 * en));
    for (int w = 0; w < en; w++) begin
      logic [31:0] got = '0;
      string req;
      for (int b = 0; b < 4; b++) begin
        logic [10:0] f = bq[(4 * w + b) & 255];
        got = {got[23:0], f[7:0]};
        if (f[10:9] != 2'(b)) id_ok = 0;
        if (^f[8:0] != 1'b1) par_ok = 0;
      end
      if (w == 0 || w == en - 1) req = "R3";
      else if (ew[w][31:28] == 4'hE) req = "R9";
      else req = "R4";
      chk(got == ew[w], req, $sformatf("word %0d", w), got, ew[w]);
    end
    chk(id_ok, "R5", "byte id order", 32'(id_ok), 32'd1);
    chk(par_ok, "R6", "odd parity", 32'(par_ok), 32'd1);
    evexp++;
  endtask

  task automatic set_src(input int n0, n1, n2, n3, m0, m1, m2, m3);
    nw[0] = n0; nw[1] = n1; nw[2] = n2; nw[3] = n3;
    md[0] = m0; md[1] = m1; md[2] = m2; md[3] = m3;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(gd == '0, "R1", "get_data after reset", 32'(gd), 32'd0);
    chk(tok == '0, "R1", "token after reset", 32'(tok), 32'd0);
    chk(stb == 1'b0, "R1", "strobe after reset", 32'(stb), 32'd0);
  endtask

  task automatic t_mixed();   // R4 ordering with varied lengths
    set_src(1, 2, 1, 3, 0, 0, 0, 0);
    run_event(0);
  endtask

  task automatic t_single();
    set_src(1, 1, 1, 1, 0, 0, 0, 0);
    run_event(0);
  endtask

  task automatic t_err();     // R7 bypass on error, R9 mask 0100
    set_src(2, 1, 3, 1, 0, 0, 1, 0);
    run_event(0);
  endtask

  task automatic t_silent();  // R8 timeout bypass, R9 mask 0010
    set_src(1, 2, 1, 2, 0, 2, 0, 0);
    run_event(0);
  endtask

  task automatic t_both();    // R7 and R8 together, R9 mask 1001
    set_src(1, 2, 2, 1, 1, 0, 0, 2);
    run_event(0);
  endtask

  task automatic t_busy();    // R10 start during event ignored
    set_src(3, 3, 3, 3, 0, 0, 0, 0);
    run_event(1);
    set_src(1, 1, 1, 1, 0, 0, 0, 0);
    run_event(0);             // header must carry the next number only
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      nw[i] = 1; md[i] = 0; idx[i] = 0; gd_run[i] = 0;
    end
    rdy = '0; err = '0; last = '0; data = '0;
    evt_start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mixed();
    t_single();
    t_err();
    t_silent();
    t_both();
    t_busy();
    chk(bad_w == 0, "R2", "get_data pulse width", 32'(bad_w), 32'd0);
    chk(bad_s == 0, "R2", "adjacent strobes", 32'(bad_s), 32'd0);
    chk(bad_g == 0, "R7", "get_data to bypassed source (R8 too)", 32'(bad_g), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule